// File: doc/BRIEF.md
# Triggered Fractional Clock-Enable Divider

This block divides its input clock by a programmable divisor that has an integer part and a fractional part. It does not generate a new clock. It emits one-cycle enable pulses, and the average spacing between pulses equals the programmed divisor. The fractional part is spread over successive output periods by a phase accumulator. Some periods are one input cycle longer than others, so that over a full accumulator cycle the average comes out exact.

Software sees two registers. The divisor register holds a shadow copy of the divisor field. The encoded value is the divisor minus one, and the plus-one applies to the integer bits above the fraction, not to the lowest bit. The control register holds a self-clearing commit bit. Setting the commit bit asks for the shadow value to replace the divisor in use, and that change happens only at an output period boundary while the clock is enabled. The commit bit reads 1 until the new divisor is in use. While it reads 1, the shadow field is frozen.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, the divisor register reads `RESET_FIELD` (0 by default) in its field, the commit bit reads 0, and with the default the divisor is 1, so `tickOut` is high on every cycle in which `clkOn` is high.
- R2: Register address 0 holds the divisor field at bits [DIV_SHIFT+DIV_W-1:DIV_SHIFT] (bits [15:4] by default). All other bits of that register read 0, and so do addresses 2 and 3.
- R3: With a fraction of 0, the field's upper DIV_W-FRAC_W bits hold the integer part N, and every output period is exactly N+1 input cycles.
- R4: With fraction F (the lower FRAC_W bits of the field) and integer part N, each period lasts N+1 or N+2 cycles. Any 2^FRAC_W consecutive periods total 2^FRAC_W*(N+1)+F cycles.
- R5: Writing the divisor field without a commit changes neither `divInUse` nor the tick spacing.
- R6: Writing 1 to bit 0 of address 1 makes that bit read 1 on the following cycle.
- R7: `divInUse` changes only on the cycle after a cycle in which `tickOut` was high.
- R8: The commit bit still reads 1 on the first cycle the new divisor is in use, and it reads 0 one cycle later.
- R9: A write to the divisor field while the commit bit reads 1 is ignored, both in the readback and in the divisor that gets loaded.
- R10: While `clkOn` is low, there are no ticks and no divisor load, and a pending commit stays at 1 until `clkOn` returns high.
- R11: The all-ones field (integer part 255, fraction 15 by default) divides correctly with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkOn | input | 1 | Clock enable; pulses and divisor loads happen only while high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | REG_W | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | REG_W | Read data for rdAddr (combinational) |
| tickOut | output | 1 | One-cycle enable pulse at each output period boundary |
| divInUse | output | DIV_W | Divisor field currently in use |

## Verification
The division is exercised with purely integer divisors, with half and quarter fractions, and with the all-ones field. Interval lengths are measured over sixteen consecutive periods. An exact total separates a correct accumulator from one that drops or doubles carries, and the minimum and maximum interval separate correct carry placement from a wrong base count. Commits are tried mid-period against a long divisor, which shows whether a load waits for a boundary. They are also tried while the clock is disabled, and with a competing field write, which shows whether the shadow stays frozen and the commit bit holds.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  // Strobes passed from the control side to the counting datapath
  typedef struct packed {
    logic runEn;       // counting allowed this cycle
    logic loadActive;  // replace the active divisor at this boundary
  } divStrobe_t;
endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int ADDR_W      = 2,
  parameter int DIV_SHIFT   = 4,
  parameter int DIV_W       = 12,
  parameter int TRIG_BIT    = 0,
  parameter int DIV_ADDR    = 0,
  parameter int TRIG_ADDR   = 1,
  parameter logic [DIV_W-1:0] RESET_FIELD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkOn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              periodEnd,
  output logic [DIV_W-1:0]  shadowField,
  output divStrobe_t        strobes
);
  localparam logic [ADDR_W-1:0] DivA  = ADDR_W'(DIV_ADDR);
  localparam logic [ADDR_W-1:0] TrigA = ADDR_W'(TRIG_ADDR);

  logic trigPending;
  logic loadSeen;
  logic divWrite;
  logic trigWrite;
  logic unusedWr;

  assign unusedWr  = ^wrData;
  assign divWrite  = wrEn && (wrAddr == DivA) && !trigPending;
  assign trigWrite = wrEn && (wrAddr == TrigA) && wrData[TRIG_BIT] && !trigPending;

  always_comb begin
    strobes.runEn      = clkOn;
    strobes.loadActive = trigPending && !loadSeen && periodEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowField <= RESET_FIELD;
      trigPending <= 1'b0;
      loadSeen    <= 1'b0;
    end else begin
      if (divWrite) shadowField <= wrData[DIV_SHIFT +: DIV_W];
      loadSeen <= strobes.loadActive;
      if (trigWrite)     trigPending <= 1'b1;
      else if (loadSeen) trigPending <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == DivA)       rdData[DIV_SHIFT +: DIV_W] = shadowField;
    else if (rdAddr == TrigA) rdData[TRIG_BIT] = trigPending;
  end

  // R9: the shadow field is frozen while a commit is outstanding
  p_shadow_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(trigPending) |-> $stable(shadowField));

  // R8: the commit bit drops exactly two edges after the load strobe
  p_trig_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigPending) |-> $past(strobes.loadActive, 2));

  // R10: no load is requested while the clock is off
  p_no_load_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !clkOn |-> !strobes.loadActive);
endmodule

// File: rtl/fdiv_datapath.sv
module fdiv_datapath
  import fdiv_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4,
  parameter logic [DIV_W-1:0] RESET_FIELD = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobes,
  input  logic [DIV_W-1:0] shadowField,
  output logic             periodEnd,
  output logic [DIV_W-1:0] activeField
);
  localparam int INT_W = DIV_W - FRAC_W;
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [INT_W-1:0] activeInt;
  logic [INT_W-1:0] shadowInt;
  logic             carry;
  logic [CNT_W-1:0] cntReload;

  assign activeInt = activeField[DIV_W-1:FRAC_W];
  assign shadowInt = shadowField[DIV_W-1:FRAC_W];
  assign periodEnd = strobes.runEn && (cnt == '0);

  generate
    if (FRAC_W > 0) begin : g_frac
      logic [FRAC_W-1:0] acc;
      logic [FRAC_W:0]   accSum;
      assign accSum = {1'b0, acc} + {1'b0, activeField[FRAC_W-1:0]};
      assign carry  = accSum[FRAC_W];
      always_ff @(posedge clk) begin
        if (!rstN) acc <= '0;
        else if (periodEnd)
          acc <= strobes.loadActive ? shadowField[FRAC_W-1:0] : accSum[FRAC_W-1:0];
      end
    end else begin : g_int
      assign carry = 1'b0;
    end
  endgenerate

  assign cntReload = strobes.loadActive ? {1'b0, shadowInt}
                                        : ({1'b0, activeInt} + CNT_W'(carry));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeField <= RESET_FIELD;
      cnt         <= '0;
    end else if (periodEnd) begin
      cnt <= cntReload;
      if (strobes.loadActive) activeField <= shadowField;
    end else if (strobes.runEn) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R7: the active divisor only changes right after a period boundary
  p_load_boundary_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeField) |-> $past(periodEnd));

  // R10: a disabled clock freezes the counter and the divisor
  p_gate_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strobes.runEn) |-> ($stable(cnt) && $stable(activeField)));

  // R4: a period never exceeds the integer part plus one carry
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= ({1'b0, activeInt} + CNT_W'(1)));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fdiv_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int ADDR_W    = 2,
  parameter int DIV_SHIFT = 4,
  parameter int DIV_W     = 12,
  parameter int FRAC_W    = 4,
  parameter int TRIG_BIT  = 0,
  parameter logic [DIV_W-1:0] RESET_FIELD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkOn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic              tickOut,
  output logic [DIV_W-1:0]  divInUse
);
  divStrobe_t       strobes;
  logic             periodEnd;
  logic [DIV_W-1:0] shadowField;

  fdiv_ctrl #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .DIV_SHIFT(DIV_SHIFT), .DIV_W(DIV_W),
    .TRIG_BIT(TRIG_BIT), .DIV_ADDR(0), .TRIG_ADDR(1), .RESET_FIELD(RESET_FIELD)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .clkOn(clkOn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .periodEnd(periodEnd),
    .shadowField(shadowField), .strobes(strobes)
  );

  fdiv_datapath #(
    .DIV_W(DIV_W), .FRAC_W(FRAC_W), .RESET_FIELD(RESET_FIELD)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shadowField(shadowField),
    .periodEnd(periodEnd), .activeField(divInUse)
  );

  assign tickOut = periodEnd;
endmodule

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkOn = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        tickOut;
  logic [11:0] divInUse;

  int nChecks = 0;
  int nFails  = 0;

  frac_clk_div i_frac_clk_div (
    .clk(clk), .rstN(rstN), .clkOn(clkOn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .tickOut(tickOut),
    .divInUse(divInUse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] mkField(int n, int f);
    return {n[7:0], f[3:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic waitClear(output int cycles);
    logic [31:0] v;
    cycles = 0;
    regRead(1, v);
    while (v[0] && cycles < 5000) begin
      @(negedge clk); cycles++; regRead(1, v);
    end
  endtask

  task automatic commit(input logic [11:0] f);
    int c;
    regWrite(0, {16'h0, f, 4'h0});
    regWrite(1, 32'h1);
    waitClear(c);
  endtask

  task automatic measure(input int n, output int total, output int minP, output int maxP);
    int guard = 0;
    total = 0; minP = 1 << 30; maxP = 0;
    while (!tickOut && guard < 5000) begin @(negedge clk); guard++; end
    for (int i = 0; i < n; i++) begin
      int c = 0;
      do begin @(negedge clk); c++; end while (!tickOut && c < 5000);
      total += c;
      if (c < minP) minP = c;
      if (c > maxP) maxP = c;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    int tot, mn, mx;
    regRead(0, v); check(v == 32'h0, "R1 divisor reg after reset", v, 0);
    regRead(1, v); check(v == 32'h0, "R1 commit bit after reset", v, 0);
    measure(8, tot, mn, mx);
    check(tot == 8, "R1 tick every cycle", tot, 8);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    int c;
    regWrite(0, 32'hFFFF_FFFF);
    regRead(0, v); check(v == 32'h0000_FFF0, "R2 field-only readback", v, 32'hFFF0);
    regRead(2, v); check(v == 32'h0, "R2 unused address", v, 0);
    regRead(3, v); check(v == 32'h0, "R2 unused address", v, 0);
    regWrite(0, 32'h0);
    check(divInUse == 12'h0, "R5 no commit keeps divisor", divInUse, 0);
    repeat (3) @(negedge clk);
    check(divInUse == 12'h0, "R5 still old divisor", divInUse, 0);
  endtask

  task automatic t_integer;
    int tot, mn, mx;
    commit(mkField(3, 0));
    check(divInUse == mkField(3, 0), "R3 divisor loaded", divInUse, mkField(3, 0));
    measure(16, tot, mn, mx);
    check(tot == 64 && mn == 4 && mx == 4, "R3 integer period 4", tot, 64);
    commit(mkField(6, 0));
    measure(16, tot, mn, mx);
    check(tot == 112 && mn == 7 && mx == 7, "R3 integer period 7", tot, 112);
  endtask

  task automatic t_frac(input int n, input int f);
    int tot, mn, mx;
    commit(mkField(n, f));
    measure(16, tot, mn, mx);
    check(tot == 16*(n+1)+f, "R4 fractional total", tot, 16*(n+1)+f);
    check(mn >= n+1 && mx <= n+2, "R4 period range", mx, n+2);
  endtask

  task automatic t_shadow_only;
    int tot, mn, mx;
    commit(mkField(4, 0));
    regWrite(0, {16'h0, mkField(1, 0), 4'h0});
    measure(8, tot, mn, mx);
    check(tot == 40, "R5 uncommitted field has no effect", tot, 40);
    check(divInUse == mkField(4, 0), "R5 divInUse unchanged", divInUse, mkField(4, 0));
  endtask

  task automatic t_commit_timing;
    logic [31:0] v;
    logic prevTick;
    logic [11:0] oldDiv;
    int guard = 0;
    commit(mkField(9, 0));
    oldDiv = divInUse;
    regWrite(0, {16'h0, mkField(2, 0), 4'h0});
    regWrite(1, 32'h1);
    regRead(1, v); check(v[0] == 1'b1, "R6 commit bit set", v[0], 1);
    prevTick = tickOut;
    while (divInUse == oldDiv && guard < 100) begin
      prevTick = tickOut;
      @(negedge clk); guard++;
    end
    check(prevTick == 1'b1, "R7 load follows a tick", prevTick, 1);
    regRead(1, v); check(v[0] == 1'b1, "R8 commit still 1 at load", v[0], 1);
    @(negedge clk);
    regRead(1, v); check(v[0] == 1'b0, "R8 commit clears next cycle", v[0], 0);
  endtask

  task automatic t_ignore_write;
    logic [31:0] v;
    int c;
    commit(mkField(20, 0));
    regWrite(0, {16'h0, mkField(5, 3), 4'h0});
    regWrite(1, 32'h1);
    regWrite(0, {16'h0, mkField(7, 9), 4'h0});
    regRead(0, v); check(v[15:4] == mkField(5, 3), "R9 pending write ignored", v[15:4], mkField(5, 3));
    waitClear(c);
    check(divInUse == mkField(5, 3), "R9 loaded first value", divInUse, mkField(5, 3));
  endtask

  task automatic t_gate;
    logic [31:0] v;
    int ticks = 0;
    int c;
    commit(mkField(2, 0));
    clkOn = 1'b0;
    regWrite(0, {16'h0, mkField(5, 0), 4'h0});
    regWrite(1, 32'h1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tickOut) ticks++;
    end
    check(ticks == 0, "R10 no ticks while off", ticks, 0);
    regRead(1, v); check(v[0] == 1'b1, "R10 commit held while off", v[0], 1);
    check(divInUse == mkField(2, 0), "R10 no load while off", divInUse, mkField(2, 0));
    clkOn = 1'b1;
    waitClear(c);
    check(divInUse == mkField(5, 0), "R10 load after enable", divInUse, mkField(5, 0));
  endtask

  task automatic t_max;
    int tot, mn, mx;
    commit(12'hFFF);
    measure(16, tot, mn, mx);
    check(tot == 16*256+15, "R11 all-ones field total", tot, 16*256+15);
    check(mn == 256 && mx == 257, "R11 all-ones period range", mx, 257);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_integer();
    t_frac(2, 8);
    t_frac(1, 4);
    t_frac(0, 15);
    t_shadow_only();
    t_commit_timing();
    t_ignore_write();
    t_gate();
    t_max();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule